// File: doc/BRIEF.md
# Flash Bank Erase and Program Engine

This block is a hardware master for a byte-wide flash device that is driven through a command and status register interface. A single request starts one of two operations on one fixed-size bank. An erase request clears the whole bank. A program request writes every byte of the bank from a ready/valid byte stream. During either operation the block runs the device's command sequences on a simple flash bus: a byte address, write data, read data, a write strobe and a read strobe. It polls the device status until the operation completes. It then returns the device to status-clear and read-array state and reads the whole bank back to verify the result.

A request is accepted only while the block is idle. Busy then stays high until a one-cycle done pulse, and done posts three results: a timeout flag, a verify-failure flag and the status error bits collected during polling. For program verification, the source stream must supply the bank's bytes a second time in the same order. The block stores no copy of the data, so it compares each read-back byte against the re-streamed byte.

Top module: `flash_bank_prog`

## Requirements
- R1: Out of reset, busy, done, timedOut, verifyFail and statusErr are zero, and neither flashWe nor flashRe is asserted while the block is idle.
- R2: In idle, a high startErase or startProgram is accepted with bankSel. If both are high, erase wins. Busy rises in the cycle after acceptance and stays high through the done cycle. Requests made while busy are ignored.
- R3: An erase writes 0x20 and then 0xD0 to the bank base address, which is bankSel times BANK_BYTES. No other bank is touched.
- R4: Each status poll writes 0x70 to the bank base and then reads one byte. Bit 7 of that byte set to 1 means the operation is complete. Polling repeats until it completes.
- R5: Each program byte is written as follows. First 0x40 goes to the byte's address. Then exactly CLK_MHZ idle cycles pass (about 1 µs), so the data write lands CLK_MHZ+1 cycles after the setup write. Then the next source byte is written to the same address, taken on srcValid and srcReady both high. Addresses run in ascending order across the whole bank.
- R6: A poll sequence that reads POLL_LIMIT status bytes without bit 7 set gives up. In that case timedOut is set, no further byte is programmed, and no verify read-back is made.
- R7: After an operation completes or times out, 0x50 and then 0xFF are written to the bank base, and these are the last two bus writes of the operation.
- R8: After a successful erase, every byte of the bank is read once. If any byte differs from 0xFF, verifyFail is set.
- R9: After a successful program, every byte of the bank is read once and compared with a second pass of the source stream. If any byte differs, verifyFail is set.
- R10: Bits 5:3 of every status byte read are OR-ed into statusErr, even when the operation then completes normally.
- R11: Done is a one-cycle pulse at the end of each operation. timedOut, verifyFail and statusErr hold their values until the next request is accepted, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startErase | input | 1 | Erase request |
| startProgram | input | 1 | Program request |
| bankSel | input | BANK_W | Bank index for the request |
| srcValid | input | 1 | Source byte valid |
| srcData | input | 8 | Source byte |
| srcReady | output | 1 | Source byte taken this cycle |
| flashAddr | output | BANK_W+IDX_W | Flash byte address |
| flashWdata | output | 8 | Flash write data |
| flashWe | output | 1 | Flash write strobe |
| flashRe | output | 1 | Flash read strobe; data is expected on flashRdata in the next cycle |
| flashRdata | input | 8 | Flash read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| timedOut | output | 1 | Polling gave up |
| verifyFail | output | 1 | Read-back mismatch |
| statusErr | output | 3 | Accumulated status error bits 5:3 |

## Verification
The bench drives both operations against a behavioural flash model whose ready latency, error bits, stuck-busy mode and single-byte corruption can each be injected. Clean erases and programs with different data seeds show that addresses, data ordering and the setup-to-data gap are correct. Stuck-busy runs separate the timeout path from normal completion by the count of status reads, program writes and verify reads. Corrupted bytes and a hole left by erase tell the verify comparison apart from the completion logic. Simultaneous requests and requests made while busy expose the priority and the rule that ignores a request while busy.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
  localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
  localparam logic [7:0] CMD_STAT_READ   = 8'h70;
  localparam logic [7:0] CMD_STAT_CLEAR  = 8'h50;
  localparam logic [7:0] CMD_ARRAY_MODE  = 8'hFF;

  typedef struct packed {
    logic       loadReq;
    logic       idxClr;
    logic       idxInc;
    logic       waitLoad;
    logic       pollClr;
    logic       pollInc;
    logic       errCapture;
    logic       setTimeout;
    logic       setMismatch;
    logic       busWe;
    logic       busRe;
    logic       addrIdx;
    logic       dataSrc;
    logic       cmpSrc;
    logic [7:0] cmd;
  } fbp_strobe_t;

  typedef struct packed {
    logic idxLast;
    logic waitDone;
    logic pollExpired;
    logic ready;
    logic mismatch;
  } fbp_status_t;

endpackage

// File: rtl/fbp_datapath.sv
module fbp_datapath
  import fbp_pkg::*;
#(
  parameter int BANK_BYTES = 8192,
  parameter int NUM_BANKS  = 2,
  parameter int WAIT_CYC   = 250,
  parameter int POLL_LIMIT = 1000000,
  localparam int IDX_W  = $clog2(BANK_BYTES),
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int WAIT_W = $clog2(WAIT_CYC + 1),
  localparam int POLL_W = $clog2(POLL_LIMIT + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  fbp_strobe_t             stb,
  output fbp_status_t             st,
  input  logic [BANK_W-1:0]       bankSel,
  input  logic [7:0]              srcData,
  output logic [BANK_W+IDX_W-1:0] flashAddr,
  output logic [7:0]              flashWdata,
  output logic                    flashWe,
  output logic                    flashRe,
  input  logic [7:0]              flashRdata,
  output logic                    timedOut,
  output logic                    verifyFail,
  output logic [2:0]              statusErr
);

  logic [BANK_W-1:0] bankReg;
  logic [IDX_W-1:0]  idx;
  logic [WAIT_W-1:0] waitCnt;
  logic [POLL_W-1:0] pollCnt;
  logic [2:0]        errAcc;
  logic              timedOutR;
  logic              failR;
  logic [7:0]        expectByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankReg   <= '0;
      idx       <= '0;
      waitCnt   <= '0;
      pollCnt   <= '0;
      errAcc    <= '0;
      timedOutR <= 1'b0;
      failR     <= 1'b0;
    end else begin
      if (stb.loadReq) begin
        bankReg   <= bankSel;
        idx       <= '0;
        errAcc    <= '0;
        timedOutR <= 1'b0;
        failR     <= 1'b0;
      end else begin
        if (stb.idxClr)      idx <= '0;
        else if (stb.idxInc) idx <= idx + 1'b1;
        if (stb.errCapture)  errAcc <= errAcc | flashRdata[5:3];
        if (stb.setTimeout)  timedOutR <= 1'b1;
        if (stb.setMismatch && st.mismatch) failR <= 1'b1;
      end
      if (stb.waitLoad)      waitCnt <= WAIT_W'(WAIT_CYC - 1);
      else if (waitCnt != '0) waitCnt <= waitCnt - 1'b1;
      if (stb.pollClr)       pollCnt <= '0;
      else if (stb.pollInc)  pollCnt <= pollCnt + 1'b1;
    end
  end

  assign expectByte  = stb.cmpSrc ? srcData : 8'hFF;
  assign flashAddr   = {bankReg, (stb.addrIdx ? idx : IDX_W'(0))};
  assign flashWdata  = stb.dataSrc ? srcData : stb.cmd;
  assign flashWe     = stb.busWe;
  assign flashRe     = stb.busRe;
  assign timedOut    = timedOutR;
  assign verifyFail  = failR;
  assign statusErr   = errAcc;

  assign st.idxLast     = (idx == IDX_W'(BANK_BYTES - 1));
  assign st.waitDone    = (waitCnt == '0);
  assign st.pollExpired = (pollCnt == POLL_W'(POLL_LIMIT - 1));
  assign st.ready       = flashRdata[7];
  assign st.mismatch    = (flashRdata != expectByte);

  AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(flashWe && flashRe)); // R4

  AST_NO_DATA_AFTER_TIMEOUT: assert property (@(posedge clk) disable iff (!rstN)
    timedOutR |-> !(flashWe && stb.dataSrc)); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadReq |=> ((errAcc & $past(errAcc)) == $past(errAcc))); // R10

endmodule

// File: rtl/fbp_ctrl.sv
module fbp_ctrl
  import fbp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startErase,
  input  logic        startProgram,
  input  logic        srcValid,
  input  fbp_status_t st,
  output fbp_strobe_t stb,
  output logic        srcReady,
  output logic        busy,
  output logic        done
);

  typedef enum logic [3:0] {
    S_IDLE, S_ER_SETUP, S_ER_GO, S_PG_SETUP, S_PG_WAIT, S_PG_DATA,
    S_PO_CMD, S_PO_READ, S_PO_CHECK, S_CLR, S_RST, S_VR_READ, S_VR_CHECK,
    S_FINISH
  } fbp_state_e;

  fbp_state_e state, nextState;
  logic       isProg;
  logic       aborted;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      isProg  <= 1'b0;
      aborted <= 1'b0;
    end else begin
      state <= nextState;
      if (stb.loadReq) begin
        isProg  <= !startErase;
        aborted <= 1'b0;
      end else if (stb.setTimeout) begin
        aborted <= 1'b1;
      end
    end
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    srcReady  = 1'b0;
    done      = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (startErase || startProgram) begin
          stb.loadReq = 1'b1;
          nextState   = startErase ? S_ER_SETUP : S_PG_SETUP;
        end
      end
      S_ER_SETUP: begin
        stb.busWe = 1'b1; stb.cmd = CMD_ERASE_SETUP;
        nextState = S_ER_GO;
      end
      S_ER_GO: begin
        stb.busWe = 1'b1; stb.cmd = CMD_ERASE_GO; stb.pollClr = 1'b1;
        nextState = S_PO_CMD;
      end
      S_PG_SETUP: begin
        stb.busWe = 1'b1; stb.addrIdx = 1'b1; stb.cmd = CMD_PROG_SETUP;
        stb.waitLoad = 1'b1;
        nextState = S_PG_WAIT;
      end
      S_PG_WAIT: begin
        if (st.waitDone) nextState = S_PG_DATA;
      end
      S_PG_DATA: begin
        if (srcValid) begin
          stb.busWe = 1'b1; stb.addrIdx = 1'b1; stb.dataSrc = 1'b1;
          stb.pollClr = 1'b1; srcReady = 1'b1;
          nextState = S_PO_CMD;
        end
      end
      S_PO_CMD: begin
        stb.busWe = 1'b1; stb.cmd = CMD_STAT_READ;
        nextState = S_PO_READ;
      end
      S_PO_READ: begin
        stb.busRe = 1'b1;
        nextState = S_PO_CHECK;
      end
      S_PO_CHECK: begin
        stb.errCapture = 1'b1;
        if (st.ready) begin
          if (isProg && !st.idxLast) begin
            stb.idxInc = 1'b1;
            nextState  = S_PG_SETUP;
          end else begin
            nextState = S_CLR;
          end
        end else if (st.pollExpired) begin
          stb.setTimeout = 1'b1;
          nextState      = S_CLR;
        end else begin
          stb.pollInc = 1'b1;
          nextState   = S_PO_CMD;
        end
      end
      S_CLR: begin
        stb.busWe = 1'b1; stb.cmd = CMD_STAT_CLEAR;
        nextState = S_RST;
      end
      S_RST: begin
        stb.busWe = 1'b1; stb.cmd = CMD_ARRAY_MODE;
        if (aborted) nextState = S_FINISH;
        else begin
          stb.idxClr = 1'b1;
          nextState  = S_VR_READ;
        end
      end
      S_VR_READ: begin
        stb.busRe = 1'b1; stb.addrIdx = 1'b1;
        nextState = S_VR_CHECK;
      end
      S_VR_CHECK: begin
        if (!isProg || srcValid) begin
          stb.cmpSrc      = isProg;
          stb.setMismatch = 1'b1;
          srcReady        = isProg;
          if (st.idxLast) nextState = S_FINISH;
          else begin
            stb.idxInc = 1'b1;
            nextState  = S_VR_READ;
          end
        end
      end
      S_FINISH: begin
        done      = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R11

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy); // R2

  AST_SRC_HANDSHAKE: assert property (@(posedge clk) disable iff (!rstN)
    srcReady |-> srcValid); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(stb.busWe || stb.busRe)); // R1

endmodule

// File: rtl/flash_bank_prog.sv
module flash_bank_prog
  import fbp_pkg::*;
#(
  parameter int BANK_BYTES = 8192,
  parameter int NUM_BANKS  = 2,
  parameter int CLK_MHZ    = 250,
  parameter int POLL_LIMIT = 1000000,
  localparam int IDX_W    = $clog2(BANK_BYTES),
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int WAIT_CYC = (CLK_MHZ < 1) ? 1 : CLK_MHZ
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    startErase,
  input  logic                    startProgram,
  input  logic [BANK_W-1:0]       bankSel,
  input  logic                    srcValid,
  input  logic [7:0]              srcData,
  output logic                    srcReady,
  output logic [BANK_W+IDX_W-1:0] flashAddr,
  output logic [7:0]              flashWdata,
  output logic                    flashWe,
  output logic                    flashRe,
  input  logic [7:0]              flashRdata,
  output logic                    busy,
  output logic                    done,
  output logic                    timedOut,
  output logic                    verifyFail,
  output logic [2:0]              statusErr
);

  fbp_strobe_t stb;
  fbp_status_t st;

  fbp_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startErase  (startErase),
    .startProgram(startProgram),
    .srcValid    (srcValid),
    .st          (st),
    .stb         (stb),
    .srcReady    (srcReady),
    .busy        (busy),
    .done        (done)
  );

  fbp_datapath #(
    .BANK_BYTES(BANK_BYTES),
    .NUM_BANKS (NUM_BANKS),
    .WAIT_CYC  (WAIT_CYC),
    .POLL_LIMIT(POLL_LIMIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .st        (st),
    .bankSel   (bankSel),
    .srcData   (srcData),
    .flashAddr (flashAddr),
    .flashWdata(flashWdata),
    .flashWe   (flashWe),
    .flashRe   (flashRe),
    .flashRdata(flashRdata),
    .timedOut  (timedOut),
    .verifyFail(verifyFail),
    .statusErr (statusErr)
  );

endmodule

// File: tb/flash_bank_prog_bench.sv
module flash_bank_prog_bench;

  localparam int BANK = 64;
  localparam int NB   = 2;
  localparam int MHZ  = 4;
  localparam int POLL = 12;
  localparam int AW   = $clog2(BANK) + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startErase = 1'b0, startProgram = 1'b0;
  logic [0:0] bankSel = '0;
  logic srcValid, srcReady;
  logic [7:0] srcData;
  logic [AW-1:0] flashAddr;
  logic [7:0] flashWdata, flashRdata;
  logic flashWe, flashRe, busy, done, timedOut, verifyFail;
  logic [2:0] statusErr;

  always #2 clk = ~clk;

  flash_bank_prog #(.BANK_BYTES(BANK), .NUM_BANKS(NB), .CLK_MHZ(MHZ), .POLL_LIMIT(POLL))
  u_flash_bank_prog (
    .clk(clk), .rstN(rstN), .startErase(startErase), .startProgram(startProgram),
    .bankSel(bankSel), .srcValid(srcValid), .srcData(srcData), .srcReady(srcReady),
    .flashAddr(flashAddr), .flashWdata(flashWdata), .flashWe(flashWe), .flashRe(flashRe),
    .flashRdata(flashRdata), .busy(busy), .done(done), .timedOut(timedOut),
    .verifyFail(verifyFail), .statusErr(statusErr)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // source stream: restarts at byte 0 whenever the block is idle
  int seed = 0;
  int srcIdx = 0;
  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37) + seed);
  endfunction
  assign srcValid = 1'b1;
  assign srcData  = pat(srcIdx);
  always @(posedge clk) begin
    if (!busy) srcIdx <= 0;
    else if (srcValid && srcReady) srcIdx <= (srcIdx + 1) % BANK;
  end

  // behavioural flash device
  logic [7:0] fmem [NB*BANK];
  int statusMode = 0, pend = 0, busyLeft = 0, latency = 1, stuck = 0;
  logic [2:0] injErr = '0;
  int corruptAddr = -1, eraseHole = -1;
  int eraseOps = 0, progOps = 0, statusReads = 0, cmd70 = 0, arrayReads = 0;
  int eraseBase = -1, gapBad = 0, addrBad = 0, setupCyc = 0, setupAddr = 0, cyc = 0;
  int lastAddr = -1;
  logic [7:0] hist1 = '0, hist2 = '0;

  always @(posedge clk) begin
    int a;
    cyc++;
    a = int'(flashAddr);
    if (flashWe) begin
      hist2 = hist1; hist1 = flashWdata;
      if (pend == 1) begin
        pend = 0;
        if (flashWdata == 8'hD0) begin
          eraseOps++; eraseBase = a;
          for (int k = 0; k < BANK; k++) begin
            int m;
            m = (a / BANK) * BANK + k;
            fmem[m] = (m == eraseHole) ? 8'h00 : 8'hFF;
          end
          busyLeft = latency; statusMode = 1;
        end
      end else if (pend == 2) begin
        pend = 0; progOps++;
        if (cyc - setupCyc != MHZ + 1) gapBad++;
        if (a != setupAddr || a <= lastAddr) addrBad++;
        lastAddr = a;
        fmem[a] = (a == corruptAddr) ? (flashWdata ^ 8'h01) : flashWdata;
        busyLeft = latency; statusMode = 1;
      end else begin
        case (flashWdata)
          8'h20: pend = 1;
          8'h40: begin pend = 2; setupCyc = cyc; setupAddr = a; end
          8'h70: begin statusMode = 1; cmd70++; end
          8'hFF: statusMode = 0;
          default: ;
        endcase
      end
    end
    if (flashRe) begin
      if (statusMode != 0) begin
        statusReads++;
        flashRdata <= {(stuck == 0 && busyLeft == 0), 1'b0, injErr, 3'b000};
        if (busyLeft > 0) busyLeft--;
      end else begin
        arrayReads++;
        flashRdata <= fmem[a];
      end
    end
  end

  task automatic clearModel();
    eraseOps = 0; progOps = 0; statusReads = 0; cmd70 = 0; arrayReads = 0;
    eraseBase = -1; gapBad = 0; addrBad = 0; lastAddr = -1;
    stuck = 0; injErr = '0; corruptAddr = -1; eraseHole = -1; latency = 1;
  endtask

  task automatic fillBank(input int bank, input int base);
    for (int k = 0; k < BANK; k++) fmem[bank*BANK + k] = 8'(base + k * 13);
  endtask

  logic rTo, rVf;
  logic [2:0] rErr;

  task automatic runOp(input bit e, input bit p, input int bank);
    int n;
    @(negedge clk);
    startErase = e; startProgram = p; bankSel = 1'(bank);
    @(negedge clk);
    startErase = 1'b0; startProgram = 1'b0;
    chk(busy == 1'b1, "R2", "busy after accept", busy, 1);
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk(n < 20000, "R11", "done pulse seen", done, 1);
    rTo = timedOut; rVf = verifyFail; rErr = statusErr;
    @(negedge clk);
    chk(!busy && !done, "R11", "busy and done low after end", {busy, done}, 0);
  endtask

  task automatic t_reset();
    chk(!busy && !done, "R1", "busy/done at reset", {busy, done}, 0);
    chk(!timedOut && !verifyFail && statusErr == 0, "R1", "flags at reset",
        {timedOut, verifyFail, statusErr}, 0);
    chk(!flashWe && !flashRe, "R1", "bus strobes idle", {flashWe, flashRe}, 0);
  endtask

  task automatic t_erase_clean();
    int bad, changed;
    clearModel(); latency = 2;
    fillBank(0, 3); fillBank(1, 5);
    runOp(1, 0, 1);
    chk(eraseOps == 1, "R3", "erase op count", eraseOps, 1);
    chk(eraseBase == BANK, "R3", "erase base address", eraseBase, BANK);
    bad = 0; changed = 0;
    for (int k = 0; k < BANK; k++) begin
      if (fmem[BANK + k] != 8'hFF) bad++;
      if (fmem[k] != 8'(3 + k * 13)) changed++;
    end
    chk(bad == 0, "R3", "erased bytes not FF", bad, 0);
    chk(changed == 0, "R3", "other bank disturbed", changed, 0);
    chk(statusReads == 3 && cmd70 == 3, "R4", "status reads for latency 2", statusReads, 3);
    chk(hist2 == 8'h50 && hist1 == 8'hFF, "R7", "last two writes", {hist2, hist1}, 16'h50FF);
    chk(arrayReads == BANK, "R8", "erase verify reads", arrayReads, BANK);
    chk(!rVf && !rTo, "R8", "erase flags", {rTo, rVf}, 0);
  endtask

  task automatic t_program_clean(input int s, input int bank);
    int bad;
    clearModel(); seed = s;
    runOp(0, 1, bank);
    chk(progOps == BANK, "R5", "program byte count", progOps, BANK);
    chk(gapBad == 0, "R5", "setup-to-data gap errors", gapBad, 0);
    chk(addrBad == 0, "R5", "address order errors", addrBad, 0);
    bad = 0;
    for (int k = 0; k < BANK; k++) if (fmem[bank*BANK + k] != pat(k)) bad++;
    chk(bad == 0, "R5", "programmed bytes wrong", bad, 0);
    chk(arrayReads == BANK, "R9", "program verify reads", arrayReads, BANK);
    chk(!rVf && !rTo && rErr == 0, "R9", "clean program flags", {rTo, rVf, rErr}, 0);
  endtask

  task automatic t_err_bits();
    clearModel(); seed = 9; injErr = 3'b101;
    runOp(0, 1, 1);
    chk(rErr == 3'b101, "R10", "status error bits", rErr, 5);
    chk(!rTo && !rVf, "R10", "completed despite error bits", {rTo, rVf}, 0);
    repeat (10) @(negedge clk);
    chk(statusErr == 3'b101, "R11", "error bits held after done", statusErr, 5);
    clearModel();
    runOp(1, 0, 1);
    chk(rErr == 3'b000, "R11", "error bits cleared by next request", rErr, 0);
  endtask

  task automatic t_prog_timeout();
    clearModel(); stuck = 1; seed = 2;
    runOp(0, 1, 0);
    chk(rTo == 1'b1, "R6", "timeout flag", rTo, 1);
    chk(progOps == 1, "R6", "bytes programmed after stall", progOps, 1);
    chk(statusReads == POLL, "R6", "status reads before giving up", statusReads, POLL);
    chk(arrayReads == 0, "R6", "verify reads after timeout", arrayReads, 0);
    chk(hist2 == 8'h50 && hist1 == 8'hFF, "R7", "cleanup after timeout", {hist2, hist1}, 16'h50FF);
  endtask

  task automatic t_erase_timeout();
    clearModel(); stuck = 1;
    runOp(1, 0, 1);
    chk(rTo == 1'b1 && eraseOps == 1, "R6", "erase timeout", {rTo, 8'(eraseOps)}, 257);
    chk(arrayReads == 0 && !rVf, "R6", "no verify after erase timeout", arrayReads, 0);
  endtask

  task automatic t_prog_corrupt();
    clearModel(); seed = 4; corruptAddr = 10;
    runOp(0, 1, 0);
    chk(rVf == 1'b1 && !rTo, "R9", "verify fail on corrupt byte", {rTo, rVf}, 1);
    chk(arrayReads == BANK, "R9", "whole bank read despite mismatch", arrayReads, BANK);
  endtask

  task automatic t_erase_hole();
    clearModel(); eraseHole = BANK + 5;
    runOp(1, 0, 1);
    chk(rVf == 1'b1 && !rTo, "R8", "verify fail on erase hole", {rTo, rVf}, 1);
  endtask

  task automatic t_busy_ignore();
    int n;
    clearModel(); seed = 6;
    fmem[BANK] = 8'h11;
    @(negedge clk); startProgram = 1'b1; bankSel = 1'b0;
    @(negedge clk); startProgram = 1'b0;
    repeat (20) @(negedge clk);
    startErase = 1'b1; bankSel = 1'b1;
    @(negedge clk); startErase = 1'b0;
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    @(negedge clk);
    repeat (5) @(negedge clk);
    chk(eraseOps == 0, "R2", "erase while busy ignored", eraseOps, 0);
    chk(fmem[BANK] == 8'h11 && !busy, "R2", "other bank untouched", fmem[BANK], 8'h11);
  endtask

  task automatic t_both();
    clearModel();
    runOp(1, 1, 1);
    chk(eraseOps == 1 && progOps == 0, "R2", "erase wins over program",
        eraseOps * 100 + progOps, 100);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_erase_clean();
    t_program_clean(17, 0);
    t_program_clean(91, 1);
    t_err_bits();
    t_prog_timeout();
    t_erase_timeout();
    t_prog_corrupt();
    t_erase_hole();
    t_busy_ignore();
    t_both();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule